// File: doc/BRIEF.md
# Touch ADC SPI Scan Sequencer

This block is an SPI master for an eight-input serial touch-controller ADC. After a start pulse it walks the enabled inputs from index 0 upward. For each enabled input it sends a burst of 24-bit frames. Each frame carries a command byte followed by sixteen clocks in which the ADC returns a big-endian word. The leading frames of each burst give the analog front end time to settle, and their results are dropped. The block sums the results of the remaining frames and divides the sum by their number, rounding up, to give one 12-bit value per input.

The mask, the reference selection and the per-input settling and oversampling counts are captured when the start pulse is taken, so the inputs may change while a scan runs. The averages are written to consecutive slots of a parallel result bus, one slot per enabled input. A one-cycle done pulse then marks the whole bus as valid. The bus keeps its values until the next accepted start. All ports are plain control, status and data pins with no valid/ready handshake: the result bus simply holds its contents until the next start, so no back-pressure is needed. The SPI clock is a fixed fraction of the system clock, set by a parameter.

Top module: `tadc_scan_seq`

## Requirements
- R1: SPI uses mode 0 with the MSB first. `sclk_o` idles low and is low whenever `cs_n_o` is high. `mosi_o` changes only while `sclk_o` is low, so the ADC samples it on the rising edge. `miso_i` is sampled on the rising edge. Each frame is 24 clocks: 8 clocks carry the command byte, then 16 clocks return the data word.
- R2: Command byte encoding. Bit 7 is always 1. Bits 6:4 hold the input index. Bit 3 (resolution select) is always 0. Bit 2 (single-ended select) is 1 for inputs 0, 2, 6 and 7 and 0 for the others. Bit 1 (reference on) is 1 only for those same four inputs, only when `ext_ref_i` was low at start, and only on frames that are not the last of their burst.
- R3: Bit 0 (converter on) is 1 on every frame of a burst except the last. The last frame of each burst has bits 1:0 both 0.
- R4: Each enabled input i gets skip[i] + ovs[i] frames in one unbroken burst. Bursts follow ascending input index, and disabled inputs get no frames.
- R5: The sample is bits 14:3 of the 16-bit returned word, which are received bits 20 down to 9 of the frame. Bit 15, bits 2:0 and the 8 bits received during the command byte are ignored.
- R6: The first skip[i] samples of a burst are discarded. The result is the ceiling of the sum of the remaining samples divided by their count.
- R7: Results go to consecutive slots, starting at slot 0 (bits 11:0), in ascending order of input index. Slots beyond the number of enabled inputs read 0.
- R8: The skip field is 4 bits (0 to 15). An oversampling field of 0 counts as 1, and a value above 16 counts as 16.
- R9: `cs_n_o` goes low at the first frame, stays low for the whole scan, and goes high once, in the same cycle as done. A scan with an empty mask never asserts `cs_n_o`. After reset `cs_n_o` is high.
- R10: `done_o` is high for exactly one cycle at the end of a scan. `result_o` does not change from that cycle until the next accepted start, and an accepted start clears it to 0.
- R11: A start pulse during a scan is ignored. The running scan, its frames and its results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a scan (taken only when idle) |
| ch_en_i | input | 8 | Input enable mask, bit i enables input i |
| ext_ref_i | input | 1 | External reference in use, keeps bit 1 of the command byte clear |
| skip_i | input | 32 | Settling frame count per input, 4 bits each, input i at [4i+3:4i] |
| ovs_i | input | 40 | Oversampling count per input, 5 bits each, input i at [5i+4:5i] |
| miso_i | input | 1 | Serial data from the ADC |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the ADC |
| cs_n_o | output | 1 | Active-low chip select |
| result_o | output | 96 | Averaged results, slot k at [12k+11:12k] |
| done_o | output | 1 | One-cycle scan-complete pulse |

## Verification
With the default SPI divider each frame takes 97 cycles from launch to the launch of the next frame. Each enabled input then adds about 20 cycles for the burst start and the serial division, and each skipped index adds one cycle. The bench therefore expects done no earlier than 96 cycles per frame after the start edge and no later than that count plus a small per-input allowance. It samples every output on the falling clock edge in the cycle where done is high. It checks in the next cycle that done has dropped, and a few cycles later that the result bus has held its values. The command bytes and the frame count are checked against the slave model's log once done is seen. The slave model changes `miso_i` only after a rising SPI clock edge, so each received bit lines up with the sequencer's sampling edge.

// File: rtl/tadc_pkg.sv
package tadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_XFER,
    ST_DIVGO,
    ST_DIV
  } seq_state_e;

  // Command byte: start marker, input index, 12-bit mode, single-ended
  // select, reference-on, converter-on. Power bits drop on the last frame.
  function automatic logic [7:0] tadc_cmd(input logic [2:0] ch,
                                          input logic       ext_ref,
                                          input logic       last);
    logic se;
    se = (ch == 3'd0) || (ch == 3'd2) || (ch == 3'd6) || (ch == 3'd7);
    return {1'b1, ch, 1'b0, se, se & ~ext_ref & ~last, ~last};
  endfunction

endpackage

// File: rtl/tadc_spi_frame.sv
module tadc_spi_frame #(
  parameter int FRAME_W  = 24,
  parameter int HALF_CYC = 2,
  parameter int RX_LSB   = 3,
  parameter int RX_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               done_o,
  output logic [RX_W-1:0]    rx_o
);
  localparam int CW   = $clog2(HALF_CYC) + 1;
  localparam int BW   = $clog2(FRAME_W) + 1;
  localparam int SH_W = RX_LSB + RX_W;

  logic               act_q, ph_q;
  logic [CW-1:0]      cnt_q;
  logic [BW-1:0]      bits_q;
  logic [FRAME_W-1:0] tx_q;
  logic [SH_W-1:0]    rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      bits_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        act_q  <= 1'b1;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
        bits_q <= '0;
        tx_q   <= tx_i;
        sclk_o <= 1'b0;
      end else if (act_q) begin
        if (cnt_q == CW'(HALF_CYC - 1)) begin
          cnt_q <= '0;
          if (!ph_q) begin
            sclk_o <= 1'b1;
            ph_q   <= 1'b1;
            rx_q   <= {rx_q[SH_W-2:0], miso_i};
          end else begin
            sclk_o <= 1'b0;
            ph_q   <= 1'b0;
            tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
            bits_q <= bits_q + BW'(1);
            if (bits_q == BW'(FRAME_W - 1)) begin
              act_q  <= 1'b0;
              done_o <= 1'b1;
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign mosi_o = act_q & tx_q[FRAME_W-1];
  assign rx_o   = rx_q[SH_W-1:RX_LSB];

endmodule

// File: rtl/tadc_rdiv.sv
module tadc_rdiv #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 5,
  parameter int QUO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int CW = $clog2(NUM_W) + 1;

  logic             run_q;
  logic [CW-1:0]    cnt_q;
  logic [DEN_W-1:0] rem_q, den_q, nrem;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   shifted, sub;
  logic             qbit;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    qbit    = shifted >= {1'b0, den_q};
    sub     = shifted - {1'b0, den_q};
    nrem    = qbit ? DEN_W'(sub) : DEN_W'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        rem_q <= '0;
        den_q <= den_i;
        quo_q <= num_i;
      end else if (run_q) begin
        rem_q <= nrem;
        quo_q <= {quo_q[NUM_W-2:0], qbit};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(NUM_W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = QUO_W'(quo_q);

endmodule

// File: rtl/tadc_scan_seq.sv
module tadc_scan_seq
  import tadc_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DATA_W   = 12,
  parameter int SKIP_W   = 4,
  parameter int OVS_W    = 5,
  parameter int OVS_MAX  = 16,
  parameter int HALF_CYC = 2,
  parameter int FRAME_W  = 24,
  parameter int DATA_LSB = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic                  ext_ref_i,
  input  logic [NCH*SKIP_W-1:0] skip_i,
  input  logic [NCH*OVS_W-1:0]  ovs_i,
  input  logic                  miso_i,
  output logic                  sclk_o,
  output logic                  mosi_o,
  output logic                  cs_n_o,
  output logic [NCH*DATA_W-1:0] result_o,
  output logic                  done_o
);
  localparam int CH_W  = $clog2(NCH);
  localparam int IDX_W = CH_W + 1;
  localparam int DEN_W = $clog2(OVS_MAX + 1);
  localparam int SUM_W = DATA_W + DEN_W;
  localparam int CNT_W = $clog2((1 << SKIP_W) + OVS_MAX);

  seq_state_e         st_q;
  logic [NCH-1:0]     mask_q;
  logic               ext_q, cs_q;
  logic [SKIP_W-1:0]  skip_q [NCH];
  logic [DEN_W-1:0]   ovs_q  [NCH];
  logic [DEN_W-1:0]   ovs_eff[NCH];
  logic [DATA_W-1:0]  res_q  [NCH];
  logic [IDX_W-1:0]   ch_q, slot_q;
  logic [CNT_W-1:0]   fcnt_q, total, nxt_f;
  logic [SUM_W-1:0]   acc_q;
  logic [SKIP_W-1:0]  cur_skip;
  logic [DEN_W-1:0]   cur_ovs;
  logic [CH_W-1:0]    ch_lo;
  logic               ch_end, last, launch_last, frm_go, frm_done, div_done;
  logic [FRAME_W-1:0] frm_tx;
  logic [DATA_W-1:0]  frm_rx, div_quo;

  // Clamp of the oversampling field, one lane per input.
  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic [OVS_W-1:0] ov;
    assign ov = ovs_i[g*OVS_W +: OVS_W];
    assign ovs_eff[g] = (ov == '0) ? DEN_W'(1)
                      : (int'(ov) > OVS_MAX) ? DEN_W'(OVS_MAX) : DEN_W'(ov);
    assign result_o[g*DATA_W +: DATA_W] = res_q[g];
  end

  assign ch_lo    = ch_q[CH_W-1:0];
  assign ch_end   = (ch_q == IDX_W'(NCH));
  assign cur_skip = skip_q[ch_lo];
  assign cur_ovs  = ovs_q[ch_lo];
  assign total    = CNT_W'(cur_skip) + CNT_W'(cur_ovs);
  assign last     = (fcnt_q == total - CNT_W'(1));

  always_comb begin
    frm_go = 1'b0;
    if (st_q == ST_SEEK && !ch_end && mask_q[ch_lo]) frm_go = 1'b1;
    if (st_q == ST_XFER && frm_done && !last)        frm_go = 1'b1;
    nxt_f       = (st_q == ST_SEEK) ? '0 : fcnt_q + CNT_W'(1);
    launch_last = (nxt_f == total - CNT_W'(1));
    frm_tx      = {tadc_cmd(3'(ch_lo), ext_q, launch_last), {(FRAME_W-8){1'b0}}};
  end

  tadc_spi_frame #(
    .FRAME_W(FRAME_W), .HALF_CYC(HALF_CYC), .RX_LSB(DATA_LSB), .RX_W(DATA_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .go_i(frm_go), .tx_i(frm_tx), .miso_i(miso_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .done_o(frm_done), .rx_o(frm_rx)
  );

  tadc_rdiv #(
    .NUM_W(SUM_W), .DEN_W(DEN_W), .QUO_W(DATA_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(st_q == ST_DIVGO),
    .num_i(acc_q + SUM_W'(cur_ovs) - SUM_W'(1)), .den_i(cur_ovs),
    .done_o(div_done), .quo_o(div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      ext_q  <= 1'b0;
      cs_q   <= 1'b0;
      ch_q   <= '0;
      slot_q <= '0;
      fcnt_q <= '0;
      acc_q  <= '0;
      done_o <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        skip_q[k] <= '0;
        ovs_q[k]  <= '0;
        res_q[k]  <= '0;
      end
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q <= ch_en_i;
          ext_q  <= ext_ref_i;
          ch_q   <= '0;
          slot_q <= '0;
          for (int k = 0; k < NCH; k++) begin
            skip_q[k] <= skip_i[k*SKIP_W +: SKIP_W];
            ovs_q[k]  <= ovs_eff[k];
            res_q[k]  <= '0;
          end
          st_q <= ST_SEEK;
        end
        ST_SEEK: begin
          if (ch_end) begin
            done_o <= 1'b1;
            cs_q   <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (mask_q[ch_lo]) begin
            cs_q   <= 1'b1;
            fcnt_q <= '0;
            acc_q  <= '0;
            st_q   <= ST_XFER;
          end else begin
            ch_q <= ch_q + IDX_W'(1);
          end
        end
        ST_XFER: if (frm_done) begin
          if (fcnt_q >= CNT_W'(cur_skip)) acc_q <= acc_q + SUM_W'(frm_rx);
          fcnt_q <= fcnt_q + CNT_W'(1);
          if (last) st_q <= ST_DIVGO;
        end
        ST_DIVGO: st_q <= ST_DIV;
        ST_DIV: if (div_done) begin
          res_q[slot_q[CH_W-1:0]] <= div_quo;
          slot_q <= slot_q + IDX_W'(1);
          ch_q   <= ch_q + IDX_W'(1);
          st_q   <= ST_SEEK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o = ~cs_q;

endmodule

// File: rtl/tadc_scan_chk.sv
module tadc_scan_chk #(
  parameter int RES_W = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             cs_n_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (start_i) held_q <= 1'b0;
    else if (done_o)  held_q <= 1'b1;
  end

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);                                           // R1
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));                                    // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                            // R10
  AST_CS_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o);                                             // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !start_i) |=> $stable(result_o));                    // R10

endmodule

bind tadc_scan_seq tadc_scan_chk #(.RES_W(NCH*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .cs_n_o(cs_n_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/tadc_scan_seq_tb_top.sv
module tadc_scan_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ext_ref = 1'b0;
  logic [7:0]  ch_en = '0;
  logic [31:0] skip_v = '0;
  logic [39:0] ovs_v = '0;
  logic        miso, sclk, mosi, cs_n, done;
  logic [95:0] result;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tadc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ch_en_i(ch_en),
    .ext_ref_i(ext_ref), .skip_i(skip_v), .ovs_i(ovs_v), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .result_o(result),
    .done_o(done)
  );

  // ADC slave model
  logic [11:0] rv [256];
  logic [7:0]  got_cmd [256];
  logic [7:0]  slv_cmd = '0;
  int slv_bits = 0, slv_frame = 0, cs_rises = 0;

  always @(posedge sclk) if (!cs_n) begin
    if (slv_bits < 8) slv_cmd = {slv_cmd[6:0], mosi};
    if (slv_bits == 23) begin
      got_cmd[slv_frame % 256] = slv_cmd;
      slv_frame++;
      slv_bits = 0;
    end else slv_bits++;
  end

  always @(posedge cs_n) cs_rises++;

  always_comb begin
    logic [23:0] w;
    w = {8'hA5, 1'b1, rv[slv_frame % 256], 3'b101};
    miso = w[23 - slv_bits];
  end

  // configuration and expectations
  logic [3:0] cfg_skip [8];
  logic [4:0] cfg_ovs  [8];
  logic [7:0] cfg_mask;
  bit         cfg_ext;
  logic [7:0] ecmd [256];
  int         eres [8];
  int         nfr, ngrp;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int eff_ovs(input logic [4:0] o);
    if (o == 0) return 1;
    if (o > 16) return 16;
    return int'(o);
  endfunction

  function automatic logic [7:0] want_cmd(input int ch, input bit ext, input bit last);
    logic [7:0] b;
    b = 8'h80 | 8'(ch << 4);
    if (ch == 0 || ch == 2 || ch == 6 || ch == 7) begin
      b |= 8'h04;
      if (!ext && !last) b |= 8'h02;
    end
    if (!last) b |= 8'h01;
    return b;
  endfunction

  task automatic build_expect();
    nfr = 0; ngrp = 0;
    for (int k = 0; k < 8; k++) eres[k] = 0;
    for (int ch = 0; ch < 8; ch++) if (cfg_mask[ch]) begin
      int o, t, sum;
      o = eff_ovs(cfg_ovs[ch]);
      t = int'(cfg_skip[ch]) + o;
      sum = 0;
      for (int f = 0; f < t; f++) begin
        ecmd[nfr] = want_cmd(ch, cfg_ext, f == t - 1);
        if (f >= int'(cfg_skip[ch])) sum += int'(rv[nfr]);
        nfr++;
      end
      eres[ngrp] = (sum + o - 1) / o;
      ngrp++;
    end
  endtask

  function automatic int slot(input int k);
    return int'(result[k*12 +: 12]);
  endfunction

  task automatic run_scan(input bit poke);
    int c, lo, hi, bad, first_bad;
    logic [95:0] snap;
    build_expect();
    slv_frame = 0; slv_bits = 0;
    @(negedge clk);
    cs_rises = 0;
    ch_en = cfg_mask; ext_ref = cfg_ext;
    for (int k = 0; k < 8; k++) begin
      skip_v[k*4 +: 4] = cfg_skip[k];
      ovs_v[k*5 +: 5]  = cfg_ovs[k];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done && c < 60000) begin
      if (poke && c == 40) begin start = 1'b1; ch_en = 8'hFF; ovs_v = '1; end
      if (poke && c == 41) begin start = 1'b0; ch_en = cfg_mask; end
      @(negedge clk);
      c++;
    end
    lo = nfr * 96;
    hi = nfr * 97 + 8 * 25 + 10;
    chk(done == 1'b1, "R10 done pulse seen", int'(done), 1);
    chk(c >= lo && c <= hi, "R10 done latency in window", c, lo);
    chk(slv_frame == nfr, "R4 frame count", slv_frame, nfr);
    bad = 0; first_bad = -1;
    for (int i = 0; i < nfr && i < slv_frame; i++)
      if (got_cmd[i] !== ecmd[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R1 R2 R3 command bytes (first bad frame in actual)", first_bad, -1);
    for (int k = 0; k < 8; k++) begin
      if (k < ngrp) chk(slot(k) == eres[k], "R6 averaged slot", slot(k), eres[k]);
      else          chk(slot(k) == 0, "R7 unused slot zero", slot(k), 0);
    end
    chk(cs_n == 1'b1, "R9 chip select released at done", int'(cs_n), 1);
    chk(cs_rises == (cfg_mask != 0 ? 1 : 0), "R9 chip select release count",
        cs_rises, (cfg_mask != 0 ? 1 : 0));
    snap = result;
    @(negedge clk);
    chk(done == 1'b0, "R10 done lasts one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(result == snap, "R10 results held", int'(result[11:0]), int'(snap[11:0]));
  endtask

  task automatic set_all(input int sk, input int ov);
    for (int k = 0; k < 8; k++) begin
      cfg_skip[k] = 4'(sk);
      cfg_ovs[k]  = 5'(ov);
    end
  endtask

  task automatic rand_rv();
    for (int i = 0; i < 256; i++) rv[i] = 12'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rand_rv();
    set_all(0, 1);
    cfg_mask = 8'h00; cfg_ext = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R9 reset chip select high", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 reset clock idle low", int'(sclk), 0);
    chk(done == 1'b0 && result == '0, "R10 reset outputs clear", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single input, one frame
    cfg_mask = 8'h01; run_scan(1'b0);
    // every input, internal then external reference
    cfg_mask = 8'hFF; cfg_ext = 1'b0; rand_rv(); run_scan(1'b0);
    cfg_ext = 1'b1; rand_rv(); run_scan(1'b0);
    // empty mask
    cfg_mask = 8'h00; cfg_ext = 1'b0; run_scan(1'b0);
    chk(slv_frame == 0, "R9 empty mask sends nothing", slv_frame, 0);

    // longest burst with full-scale samples and junk in ignored bits
    set_all(0, 1);
    cfg_skip[7] = 4'd15; cfg_ovs[7] = 5'd16; cfg_mask = 8'h80;
    for (int i = 0; i < 256; i++) rv[i] = 12'hFFF;
    run_scan(1'b0);
    chk(slot(0) == 4095, "R5 field extraction full scale", slot(0), 4095);

    // rounding up: kept samples 1,1,2 -> 2
    set_all(0, 1);
    cfg_skip[3] = 4'd2; cfg_ovs[3] = 5'd3; cfg_mask = 8'h08;
    rv[0] = 12'hFFF; rv[1] = 12'hFFF; rv[2] = 12'd1; rv[3] = 12'd1; rv[4] = 12'd2;
    run_scan(1'b0);
    chk(slot(0) == 2, "R6 round up", slot(0), 2);

    // oversampling clamp
    set_all(0, 1);
    cfg_skip[2] = 4'd1; cfg_ovs[2] = 5'd0;
    cfg_skip[5] = 4'd0; cfg_ovs[5] = 5'd31;
    cfg_mask = 8'h24; rand_rv();
    run_scan(1'b0);
    chk(slv_frame == 18, "R8 clamped frame total", slv_frame, 18);

    // start pulse while busy
    set_all(1, 2); cfg_mask = 8'h11; rand_rv();
    run_scan(1'b1);
    chk(slv_frame == nfr, "R11 mid-scan start ignored", slv_frame, nfr);

    // constrained random scans
    for (int n = 0; n < 10; n++) begin
      cfg_mask = 8'($urandom);
      cfg_ext  = 1'($urandom);
      for (int k = 0; k < 8; k++) begin
        cfg_skip[k] = 4'($urandom % 6);
        cfg_ovs[k]  = 5'(1 + $urandom % 6);
      end
      rand_rv();
      run_scan(1'b0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule